// File: doc/BRIEF.md
# Pipelined streaming accumulate stage

This block is the arithmetic step of a streaming integrator. It keeps no running sum of its own. The previous sum comes in on a port, and the updated sum goes out on a port. A caller can loop the output straight back to the input to get one accumulator. It can also keep many sums in an external memory and share one stage among them in time. Each sample either passes the incoming sum through unchanged, replaces it with the sample to open a new integration period, or adds the sample to it.

The data and the sum are signed two's-complement, and the sum is wider than the data. Register stages can be placed before the arithmetic and after it, and the two depths are chosen separately. A qualifier strobe travels alongside the result and has the same latency. A clock enable freezes every register in the block.

An optional mode stores a load request that arrives while the qualifier is low. The stored request then applies to the next qualified sample.

Top module: `acc_stage`

## Requirements
- R1: While `vld_i` is low, the result leaving on `acc_o` equals the `acc_i` value presented with that sample, bit for bit.
- R2: While `vld_i` and `load_i` are both high, the result equals `dat_i` sign-extended to ACC_W bits, and `acc_i` is ignored.
- R3: While `vld_i` is high and no load is in effect, the result equals `acc_i` plus `dat_i` sign-extended to ACC_W bits.
- R4: Additions wrap modulo 2^ACC_W with no saturation. For example, with ACC_W=9, 250+31 gives -231 and -256-1 gives 255.
- R5: The result for a sample appears on `acc_o` exactly IN_STAGES+OUT_STAGES enabled clock edges after that sample is presented. Only the sum of the two depths sets the latency, not how it is split.
- R6: `vld_o` repeats `vld_i` with the same latency as `acc_o`, so it is high exactly when `acc_o` carries the result of a qualified sample.
- R7: While `ce_i` is low, no register in the block changes, so `acc_o` and `vld_o` hold their values. Counting of latency resumes when `ce_i` returns high.
- R8: With HOLD_LOAD=1, a `load_i` seen while `vld_i` is low is stored and applied to the next qualified sample, and that sample clears it. With HOLD_LOAD=0, such a load has no effect.
- R9: While `rst_ni` is low, every pipeline register is cleared, so `acc_o` is 0 and `vld_o` is 0 (for nonzero total depth).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable for every register |
| load_i | input | 1 | Start of an integration period |
| dat_i | input | DAT_W | Signed input sample |
| acc_i | input | ACC_W | Signed previous sum |
| vld_i | input | 1 | Sample qualifier |
| acc_o | output | ACC_W | Signed updated sum |
| vld_o | output | 1 | Qualifier aligned with `acc_o` |

## Verification
The bench builds two copies of the block with 6-bit data and a 9-bit sum, which makes wrap-around in both directions easy to reach. One copy has one input stage, two output stages and the stored-load mode enabled. The other has two input stages, one output stage and the mode disabled. Both copies have the same total latency, so a single stimulus stream checks that the split between input and output stages does not matter. The only expected difference between the two copies is where a load arrives during an unqualified cycle.

// File: rtl/acc_stage_pkg.sv
package acc_stage_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_ADD  = 2'd2
  } acc_op_e;

endpackage

// File: rtl/acc_stage_delay.sv
module acc_stage_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] pipe_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pipe_q[s] <= '0;
        end else if (en_i) begin
          if (s == 0) pipe_q[s] <= d_i;
          else        pipe_q[s] <= pipe_q[s-1];
        end
      end
    end

    assign q_o = pipe_q[DEPTH-1];

    AST_CE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> $stable(q_o)) else $error("stage moved without enable"); // R7
  end

endmodule

// File: rtl/acc_stage_core.sv
module acc_stage_core
  import acc_stage_pkg::*;
#(
  parameter int unsigned DAT_W     = 6,
  parameter int unsigned ACC_W     = 9,
  parameter bit          HOLD_LOAD = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             vld_i,
  input  logic [DAT_W-1:0] dat_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [ACC_W-1:0] acc_o
);

  localparam int unsigned EXT_W = ACC_W - DAT_W;

  logic             pend_q;
  logic             eff_load;
  acc_op_e          op;
  logic [ACC_W-1:0] dat_ext;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] sum;

  // stored load request, cleared by the first qualified sample
  if (HOLD_LOAD) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pend_q <= 1'b0;
      else if (en_i)   pend_q <= vld_i ? 1'b0 : (pend_q | load_i);
    end

    AST_PEND_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && vld_i) |=> !pend_q) else $error("stored load survived"); // R8
  end else begin : g_nohold
    assign pend_q = 1'b0;
  end

  always_comb begin
    eff_load = load_i | pend_q;
    if (!vld_i)        op = OP_HOLD;
    else if (eff_load) op = OP_LOAD;
    else               op = OP_ADD;
    dat_ext = {{EXT_W{dat_i[DAT_W-1]}}, dat_i};
    base    = (op == OP_LOAD) ? '0 : acc_i;
    sum     = base + dat_ext;
    acc_o   = (op == OP_HOLD) ? acc_i : sum;
  end

  AST_HOLD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |-> (acc_o == acc_i)) else $error("hold altered sum"); // R1
  AST_LOAD_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && eff_load) |-> ($signed(acc_o) == $signed(dat_i))) else $error("load not fresh"); // R2
  AST_ADD_DELTA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !eff_load) |-> (ACC_W'(acc_o - acc_i) == ACC_W'($signed(dat_i)))) else $error("bad add"); // R3

endmodule

// File: rtl/acc_stage.sv
module acc_stage #(
  parameter int unsigned DAT_W      = 6,
  parameter int unsigned ACC_W      = 9,
  parameter bit          HOLD_LOAD  = 1'b1,
  parameter int unsigned IN_STAGES  = 1,
  parameter int unsigned OUT_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             load_i,
  input  logic [DAT_W-1:0] dat_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             vld_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             vld_o
);

  localparam int unsigned IN_W  = 2 + DAT_W + ACC_W;
  localparam int unsigned OUT_W = 1 + ACC_W;

  logic [IN_W-1:0]  in_bus, in_pipe;
  logic [OUT_W-1:0] out_bus, out_pipe;
  logic             p_load, p_vld;
  logic [DAT_W-1:0] p_dat;
  logic [ACC_W-1:0] p_acc, res;

  // load, valid, sample and sum travel as one word to stay aligned
  assign in_bus = {load_i, vld_i, dat_i, acc_i};

  acc_stage_delay #(.W(IN_W), .DEPTH(IN_STAGES)) u_in_pipe (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(ce_i), .d_i(in_bus), .q_o(in_pipe)
  );

  assign {p_load, p_vld, p_dat, p_acc} = in_pipe;

  acc_stage_core #(.DAT_W(DAT_W), .ACC_W(ACC_W), .HOLD_LOAD(HOLD_LOAD)) u_core (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(ce_i),
    .load_i(p_load), .vld_i(p_vld), .dat_i(p_dat), .acc_i(p_acc), .acc_o(res)
  );

  assign out_bus = {p_vld, res};

  acc_stage_delay #(.W(OUT_W), .DEPTH(OUT_STAGES)) u_out_pipe (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(ce_i), .d_i(out_bus), .q_o(out_pipe)
  );

  assign {vld_o, acc_o} = out_pipe;

endmodule

// File: tb/tb_acc_stage.sv
module tb_acc_stage;

  localparam int DAT_W = 6;
  localparam int ACC_W = 9;
  localparam int LAT   = 3;
  localparam int NVEC  = 16;

  typedef struct packed {
    logic                    ld;
    logic                    vl;
    logic signed [DAT_W-1:0] dat;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] exp_h;
    logic signed [ACC_W-1:0] exp_n;
  } vec_t;

  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 1'b1,  6'sd5,   9'sd10,   9'sd15,   9'sd15},   // R3
    '{1'b1, 1'b1, -6'sd3,   9'sd100, -9'sd3,   -9'sd3},    // R2
    '{1'b0, 1'b0,  6'sd7,   9'sd42,   9'sd42,   9'sd42},   // R1
    '{1'b0, 1'b1, -6'sd32,  9'sd0,   -9'sd32,  -9'sd32},   // R3
    '{1'b0, 1'b1,  6'sd31,  9'sd250, -9'sd231, -9'sd231},  // R4
    '{1'b0, 1'b1, -6'sd32, -9'sd250,  9'sd230,  9'sd230},  // R4
    '{1'b1, 1'b0,  6'sd9,   9'sd77,   9'sd77,   9'sd77},   // R1 R8
    '{1'b0, 1'b0,  6'sd9,  -9'sd5,   -9'sd5,   -9'sd5},    // R8
    '{1'b0, 1'b1,  6'sd4,   9'sd200,  9'sd4,    9'sd204},  // R8
    '{1'b0, 1'b1,  6'sd4,   9'sd200,  9'sd204,  9'sd204},  // R8
    '{1'b1, 1'b1,  6'sd31, -9'sd1,    9'sd31,   9'sd31},   // R2
    '{1'b0, 1'b1, -6'sd1,  -9'sd256,  9'sd255,  9'sd255},  // R4
    '{1'b0, 1'b1,  6'sd0,  -9'sd100, -9'sd100, -9'sd100},  // R3
    '{1'b1, 1'b0,  6'sd0,   9'sd33,   9'sd33,   9'sd33},   // R8
    '{1'b1, 1'b1, -6'sd8,   9'sd60,  -9'sd8,   -9'sd8},    // R2
    '{1'b0, 1'b1,  6'sd1,   9'sd60,   9'sd61,   9'sd61}    // R3
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ce = 1'b1;
  logic             load = 1'b0;
  logic             vld = 1'b0;
  logic [DAT_W-1:0] dat = '0;
  logic [ACC_W-1:0] acc = '0;
  logic [ACC_W-1:0] acc_h, acc_n;
  logic             vld_h, vld_n;
  int               checks = 0;
  int               errors = 0;

  always #10 clk = ~clk;

  acc_stage #(.DAT_W(DAT_W), .ACC_W(ACC_W), .HOLD_LOAD(1'b1), .IN_STAGES(1), .OUT_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .load_i(load), .dat_i(dat),
    .acc_i(acc), .vld_i(vld), .acc_o(acc_h), .vld_o(vld_h)
  );

  acc_stage #(.DAT_W(DAT_W), .ACC_W(ACC_W), .HOLD_LOAD(1'b0), .IN_STAGES(2), .OUT_STAGES(1)) dut_nohold (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .load_i(load), .dat_i(dat),
    .acc_i(acc), .vld_i(vld), .acc_o(acc_n), .vld_o(vld_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic v, input int d, input int a);
    load = l; vld = v; dat = DAT_W'(d); acc = ACC_W'(a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 acc_h", int'($signed(acc_h)), 0);
    chk("R9 vld_h", int'(vld_h), 0);
    chk("R9 acc_n", int'($signed(acc_n)), 0);
    chk("R9 vld_n", int'(vld_n), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: vector i applied at step i, result sampled at step i+LAT
    for (int i = 0; i < NVEC + LAT; i++) begin
      @(negedge clk);
      if (i >= LAT) begin
        chk("R1-4/R8 hold acc", int'($signed(acc_h)), int'(TBL[i-LAT].exp_h));
        chk("R5/R8 nohold acc", int'($signed(acc_n)), int'(TBL[i-LAT].exp_n));
        chk("R6 vld_h", int'(vld_h), int'(TBL[i-LAT].vl));
        chk("R6 vld_n", int'(vld_n), int'(TBL[i-LAT].vl));
      end
      if (i < NVEC) drive(TBL[i].ld, TBL[i].vl, int'(TBL[i].dat), int'(TBL[i].acc));
      else          drive(1'b0, 1'b0, 0, 0);
    end

    // R5 directed latency: one qualified sample, edges counted
    repeat (3) @(negedge clk);
    drive(1'b1, 1'b1, 12, 0);
    @(negedge clk);
    drive(1'b0, 1'b0, 0, 0);
    chk("R5 vld after 1", int'(vld_h), 0);
    @(negedge clk);
    chk("R5 vld after 2", int'(vld_h), 0);
    @(negedge clk);
    chk("R5 vld after 3", int'(vld_h), 1);
    chk("R5 acc after 3", int'($signed(acc_h)), 12);
    chk("R5 split vld", int'(vld_n), 1);
    @(negedge clk);
    chk("R5 vld after 4", int'(vld_h), 0);

    // R7 clock enable freeze
    repeat (3) @(negedge clk);
    drive(1'b0, 1'b1, 3, 10);
    @(negedge clk);
    ce = 1'b0;
    drive(1'b1, 1'b1, 9, 99);
    repeat (4) @(negedge clk);
    chk("R7 frozen vld_h", int'(vld_h), 0);
    chk("R7 frozen acc_h", int'($signed(acc_h)), 0);
    chk("R7 frozen vld_n", int'(vld_n), 0);
    drive(1'b0, 1'b0, 0, 0);
    ce = 1'b1;
    @(negedge clk);
    chk("R7 resume 2 edges", int'(vld_h), 0);
    @(negedge clk);
    chk("R7 resume vld_h", int'(vld_h), 1);
    chk("R7 resume acc_h", int'($signed(acc_h)), 13);
    chk("R7 resume acc_n", int'($signed(acc_n)), 13);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule